// File: doc/BRIEF.md
# Iterative Radix-4 Early-Exit Multiplier

This block is a sequential integer multiplier for an execution unit. A one-cycle start pulse loads two 64-bit operands and a mode. The block then retires two bits of the first operand (the scanned operand) per clock. It uses radix-4 Booth digits in the range -2..+2. Each triplet is made of the two current bits and the bit last retired, with an implicit zero below bit 0.

It stops as soon as the bits still to be scanned can no longer change the product. A caller that places the smaller-magnitude value in the scanned operand therefore gets a shorter latency. The block returns the low 64 bits of the product together with a negative flag and a zero flag for the flag-setting forms of the instruction.

Three modes exist:
- Narrow signed: operands are the low 32 bits, sign-extended.
- Narrow unsigned: operands are the low 32 bits, zero-extended.
- Wide: the full 64-bit operands are used, and the low 64 bits of the product are kept.

Top module: `mulRadix4`

## Requirements
- R1: With `wideMode`=0 and `isSigned`=0, `product` equals the 64-bit product of the zero-extended `opA[31:0]` and `opB[31:0]`.
- R2: With `wideMode`=0 and `isSigned`=1, `product` equals the 64-bit two's-complement product of the sign-extended `opA[31:0]` and `opB[31:0]`.
- R3: With `wideMode`=1, `product` equals the low 64 bits of `opA*opB`, for either value of `isSigned`.
- R4: Let X be `opA` extended to 66 bits: the narrow modes extend from bit 31 and the wide mode from bit 63, each with sign or zero fill as `isSigned` selects. The number of cycles with `busy` high is the smallest k ≥ 1 for which bits 65 down to 2k-1 of X are all equal, capped as in R6.
- R5: An all-zero scanned operand, or an all-ones signed scanned operand, completes in exactly 1 busy cycle.
- R6: Latency never exceeds 17 cycles in narrow mode (16 when signed) or 32 cycles in wide mode.
- R7: A `startIn` pulse while `busy` is high is ignored. The running operation keeps its latency and its result.
- R8: `done` is high for exactly one cycle. That cycle is the first cycle with `busy` low after the run.
- R9: While idle, `product`, `flagNeg` and `flagZero` hold their values until the next accepted `startIn`.
- R10: `flagZero` is 1 exactly when all 64 bits of `product` are 0.
- R11: `flagNeg` equals bit 63 of `product`.
- R12: `busy` rises in the cycle after an accepted `startIn`. After reset, `busy`, `done` and `product` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start pulse; accepted only when idle |
| opA | input | 64 | Scanned operand (shorter values exit sooner) |
| opB | input | 64 | Multiplicand operand |
| isSigned | input | 1 | 1 = signed operands, 0 = unsigned |
| wideMode | input | 1 | 1 = 64-bit multiply, 0 = 32-bit multiply |
| product | output | 64 | Low 64 bits of the product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flagNeg | output | 1 | Copy of product bit 63 |
| flagZero | output | 1 | Product is zero |

## Verification
The bench counts busy cycles for every operation and compares that count with the exit rule. This exposes a design that exits one step too early, drops the pending Booth carry, or misses the exit. The design must still take its 17th step for an unsigned narrow operand with bit 31 set; skipping it leaves the product short by `opB<<32`. A wide unsigned operand with bit 63 set must stop at the 32-step cap instead of running a 33rd step. The bench also uses a most-negative signed operand, all-ones and zero operands, and results of zero and of negative sign. Finally, it fires a second start in the middle of a run: a design that accepts it would return the wrong result or a changed latency.

// File: rtl/mulPkg.sv
package mulPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;
    logic step;
  } mulCtrlT;

  // Radix-4 Booth digit selections.
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_M1   = 3'd3,
    DIG_M2   = 3'd4
  } boothDigT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulStateT;

  // Decode one overlapping triplet {hi, lo, previous} into a digit.
  function automatic boothDigT decodeTriplet(input logic [2:0] trip);
    boothDigT d;
    case (trip)
      3'b001, 3'b010: d = DIG_P1;
      3'b011:         d = DIG_P2;
      3'b100:         d = DIG_M2;
      3'b101, 3'b110: d = DIG_M1;
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCtrlT           ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              isSigned,
  input  logic              wideMode,
  output logic [DATA_W-1:0] accOut,
  output logic              lastStep
);

  localparam int SCAN_W     = DATA_W + 2;
  localparam int WIDE_CAP   = DATA_W / 2;
  localparam int NARROW_CAP = HALF_W / 2 + 1;
  localparam int CNT_W      = $clog2(WIDE_CAP + 1);
  localparam int EXT_W      = SCAN_W - HALF_W;
  localparam int MEXT_W     = DATA_W - HALF_W;

  logic [DATA_W-1:0] accQ, mcandQ;
  logic [SCAN_W-1:0] scanQ;
  logic              prevQ;
  logic [CNT_W-1:0]  iterCnt, capM1Q;

  // Operand extension at load time.
  logic              aFill, bFill, wideFill;
  logic [SCAN_W-1:0] scanInit;
  logic [DATA_W-1:0] mcandInit;

  always_comb begin
    aFill    = isSigned & opA[HALF_W-1];
    bFill    = isSigned & opB[HALF_W-1];
    wideFill = isSigned & opA[DATA_W-1];
    if (wideMode) begin
      scanInit  = {{2{wideFill}}, opA};
      mcandInit = opB;
    end else begin
      scanInit  = {{EXT_W{aFill}}, opA[HALF_W-1:0]};
      mcandInit = {{MEXT_W{bFill}}, opB[HALF_W-1:0]};
    end
  end

  // One Booth step: choose a partial product and add it.
  boothDigT          digit;
  logic [DATA_W-1:0] partial, accNext;
  logic [SCAN_W-1:0] scanNext;
  logic              prevNext;

  always_comb begin
    digit = decodeTriplet({scanQ[1], scanQ[0], prevQ});
    case (digit)
      DIG_P1:  partial = mcandQ;
      DIG_P2:  partial = mcandQ << 1;
      DIG_M1:  partial = -mcandQ;
      DIG_M2:  partial = -(mcandQ << 1);
      default: partial = '0;
    endcase
    accNext  = accQ + partial;
    scanNext = {{2{scanQ[SCAN_W-1]}}, scanQ[SCAN_W-1:2]};
    prevNext = scanQ[1];
  end

  // Exit test: every unscanned bit matches the last retired bit.
  logic [SCAN_W-1:0] matchVec;
  genvar g;
  generate
    for (g = 0; g < SCAN_W; g++) begin : gMatch
      assign matchVec[g] = (scanNext[g] == prevNext);
    end
  endgenerate

  logic allMatch, capHit;
  assign allMatch = &matchVec;
  assign capHit   = (iterCnt == capM1Q);
  assign lastStep = allMatch | capHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      mcandQ  <= '0;
      scanQ   <= '0;
      prevQ   <= 1'b0;
      iterCnt <= '0;
      capM1Q  <= '0;
    end else if (ctrl.load) begin
      accQ    <= '0;
      mcandQ  <= mcandInit;
      scanQ   <= scanInit;
      prevQ   <= 1'b0;
      iterCnt <= '0;
      capM1Q  <= wideMode ? CNT_W'(WIDE_CAP - 1) : CNT_W'(NARROW_CAP - 1);
    end else if (ctrl.step) begin
      accQ    <= accNext;
      mcandQ  <= mcandQ << 2;
      scanQ   <= scanNext;
      prevQ   <= prevNext;
      iterCnt <= iterCnt + 1'b1;
    end
  end

  assign accOut = accQ;

  // R6: the step counter never passes the mode's cap.
  p_iter_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> (iterCnt <= capM1Q));

  // R4: each step shifts the multiplicand by exactly two bit positions.
  p_two_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step && !ctrl.load |=> (mcandQ == ($past(mcandQ) << 2)));

  // R9: registers are frozen whenever no strobe is asserted.
  p_hold_acc_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load && !ctrl.step |=> $stable(accQ));

endmodule

// File: rtl/mulControl.sv
module mulControl
  import mulPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    lastStep,
  output mulCtrlT ctrl,
  output logic    busy,
  output logic    done
);

  mulStateT stateQ;

  assign busy      = (stateQ == ST_RUN);
  assign ctrl.load = startIn & ~busy;
  assign ctrl.step = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      done <= busy & lastStep;
      case (stateQ)
        ST_IDLE: if (startIn) stateQ <= ST_RUN;
        ST_RUN:  if (lastStep) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R8: done lasts a single cycle.
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done coincides with the idle state.
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: every end of a run raises done.
  p_fall_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R12: an accepted start raises busy on the next cycle.
  p_start_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startIn |=> busy);

  // R7: a start during a run does not cut it short.
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy && startIn && !lastStep |=> busy);

endmodule

// File: rtl/mulRadix4.sv
module mulRadix4
  import mulPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              isSigned,
  input  logic              wideMode,
  output logic [DATA_W-1:0] product,
  output logic              busy,
  output logic              done,
  output logic              flagNeg,
  output logic              flagZero
);

  mulCtrlT ctrl;
  logic    lastStep;

  mulControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .lastStep (lastStep),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done)
  );

  mulDatapath #(.DATA_W(DATA_W), .HALF_W(HALF_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .isSigned (isSigned),
    .wideMode (wideMode),
    .accOut   (product),
    .lastStep (lastStep)
  );

  assign flagNeg  = product[DATA_W-1];
  assign flagZero = (product == '0);

  // R9: the result and flags hold while idle without a start.
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !startIn |=> $stable(product) && $stable(flagNeg) && $stable(flagZero));

  // R12: the result is cleared while an operation is loading.
  p_load_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startIn |=> (product == '0) || busy);

endmodule

// File: tb/mulRadix4_test.sv
module mulRadix4_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        isSigned = 1'b0, wideMode = 1'b0;
  logic [63:0] product;
  logic        busy, done, flagNeg, flagZero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mulRadix4 uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opA(opA), .opB(opB),
    .isSigned(isSigned), .wideMode(wideMode), .product(product),
    .busy(busy), .done(done), .flagNeg(flagNeg), .flagZero(flagZero)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [65:0] extScan(logic [63:0] a, logic sg, logic wd);
    logic [65:0] x;
    if (wd) x = {{2{sg & a[63]}}, a};
    else    x = {{34{sg & a[31]}}, a[31:0]};
    return x;
  endfunction

  function automatic logic [63:0] expProd(logic [63:0] a, logic [63:0] b,
                                          logic sg, logic wd);
    logic [63:0] ea, eb;
    if (wd) begin
      ea = a; eb = b;
    end else begin
      ea = {{32{sg & a[31]}}, a[31:0]};
      eb = {{32{sg & b[31]}}, b[31:0]};
    end
    return ea * eb;
  endfunction

  function automatic int expLat(logic [63:0] a, logic sg, logic wd);
    logic [65:0] x = extScan(a, sg, wd);
    int cap = wd ? 32 : 17;
    for (int k = 1; k <= cap; k++) begin
      logic same = 1'b1;
      for (int i = 2 * k - 1; i < 66; i++)
        if (x[i] != x[2 * k - 1]) same = 1'b0;
      if (same) return k;
    end
    return cap;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Run one multiply; optionally inject a second start after injAt cycles.
  task automatic runOp(logic [63:0] a, logic [63:0] b, logic sg, logic wd,
                       string tag, int injAt);
    int lat = 0;
    logic [63:0] ep = expProd(a, b, sg, wd);
    int el = expLat(a, sg, wd);
    logic [63:0] heldP;
    @(negedge clk);
    opA = a; opB = b; isSigned = sg; wideMode = wd; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check({"R12 busy after start ", tag}, 64'(busy), 64'd1);
    while (!done && lat < 40) begin
      if (busy) lat++;
      if (injAt > 0 && lat == injAt) begin
        opA = ~a; opB = b + 64'd3; isSigned = ~sg; wideMode = ~wd; startIn = 1'b1;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
    end
    startIn = 1'b0;
    check({"R8 busy low at done ", tag}, 64'(busy), 64'd0);
    if (injAt > 0) begin
      check({"R7 result with ignored start ", tag}, product, ep);
      check({"R7 latency with ignored start ", tag}, 64'(lat), 64'(el));
    end else begin
      check({(wd ? "R3 " : (sg ? "R2 " : "R1 ")), "product ", tag}, product, ep);
      check({"R4 latency ", tag}, 64'(lat), 64'(el));
    end
    check({"R10 zero flag ", tag}, 64'(flagZero), 64'(ep == 64'd0));
    check({"R11 negative flag ", tag}, 64'(flagNeg), 64'(ep[63]));
    heldP = product;
    @(negedge clk);
    check({"R8 done single cycle ", tag}, 64'(done), 64'd0);
    check({"R9 result held ", tag}, product, heldP);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R12 reset busy", 64'(busy), 64'd0);
    check("R12 reset done", 64'(done), 64'd0);
    check("R12 reset product", product, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 minimum latency
    runOp(64'd0, 64'h1234_5678, 1'b0, 1'b0, "R5 zero operand", 0);
    check("R5 one cycle zero", 64'(expLat(64'd0, 1'b0, 1'b0)), 64'd1);
    runOp(64'hFFFF_FFFF, 64'd77, 1'b1, 1'b0, "R5 minus one signed", 0);
    runOp(64'd1, 64'hDEAD_BEEF, 1'b0, 1'b0, "R5 one", 0);
    // R6 caps and pending Booth carry
    runOp(64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0, 1'b0, "R6 narrow unsigned max", 0);
    runOp(64'h8000_0000, 64'h8000_0000, 1'b1, 1'b0, "R6 narrow signed min", 0);
    runOp(64'h8000_0000_0000_0000, 64'h3, 1'b1, 1'b1, "R6 wide signed min", 0);
    runOp('1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, "R6 wide unsigned ones", 0);
    runOp(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R6 wide max", 0);
    // flags
    runOp(64'd5, 64'd0, 1'b1, 1'b0, "R10 zero result", 0);
    runOp(64'hFFFF_FFFE, 64'd9, 1'b1, 1'b0, "R11 negative result", 0);
    // R7 start while busy
    runOp(64'h00F0_0000, 64'h55, 1'b0, 1'b0, "R7 inject", 3);
    runOp(64'h0000_F000_0000_0000, 64'h99, 1'b1, 1'b1, "R7 inject wide", 5);

    // random, magnitude varied to spread latency
    for (int n = 0; n < 300; n++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      int sh = $urandom % 64;
      logic sg = $urandom % 2;
      logic wd = $urandom % 2;
      ra = ra >> sh;
      if ($urandom % 2) ra = -ra;
      runOp(ra, rb, sg, wd, "random", 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule